// File: doc/BRIEF.md
# Wrap-Flag Interval Timer

This block is an interrupt timer for a cartridge-side controller. It holds a 15-bit up-counter. Software loads the counter one byte at a time through a small register interface. Each rising edge of a selectable event source advances the counter by one. The source is either the CPU bus clock (M2) or the PPU address line A12. When the counter steps from its all-ones value back to zero, the block raises its interrupt request. The request stays high until software acknowledges it.

Both event lines are raw level inputs. Each one passes through its own synchronizer and rising-edge detector in the core clock domain. A12 edges are counted as they arrive, with no filtering, so one scanline can supply several counts. A wrap stops the counter, so exactly one interrupt is raised per arming. Software must write the high byte again to restart the counter.

Software uses three write selectors. One selector stops the counter and clears the request. One loads the low byte and clears the request. One loads the high byte, clears the request and starts the counter.

Top module: `irq_wrap_timer`

## Requirements
- R1: After reset, `irq` is low, the count is zero and the counter is stopped.
- R2: A write with `wr_sel`=2 loads count bits 7:0 from `wr_data[7:0]`. A write with `wr_sel`=3 loads count bits 14:8 from `wr_data[6:0]`, and `wr_data[7]` is ignored.
- R3: While the counter is running, each rising edge of the selected source adds one to the count. A stopped counter ignores all edges.
- R4: When `src_sel`=0 the counter advances on M2 rises. When `src_sel`=1 it advances on A12 rises, and every A12 rise counts. Edges on the source that is not selected have no effect.
- R5: An edge that steps the count from 0x7FFF to 0x0000 raises `irq`. `irq` then stays high until a write with selector 1, 2 or 3.
- R6: A write with `wr_sel`=1 clears `irq` and stops the counter. A write with `wr_sel`=2 clears `irq` and leaves the run state unchanged. A write with `wr_sel`=3 clears `irq` and starts the counter.
- R7: After a wrap the counter stays stopped at zero until a write with `wr_sel`=3.
- R8: A write with `wr_sel`=0 changes nothing. When a write and a counted edge fall in the same cycle, the write takes effect and the edge is dropped.
- R9: A rising edge on a raw input is counted at the clock edge that is SYNC_STAGES+1 cycles after it is first sampled. With the default of 2 stages, that is the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Write target: 0 none, 1 stop/ack, 2 low byte, 3 high byte/start |
| wr_data | input | 8 | Write data |
| src_sel | input | 1 | Event source: 0 M2, 1 A12 |
| m2 | input | 1 | Raw CPU bus clock level |
| ppu_a12 | input | 1 | Raw PPU A12 level |
| irq | output | 1 | Interrupt request, active high |

## Verification
Directed sequences load counts just below the wrap point and then supply single edges. They confirm that `irq` rises on exactly the edge that wraps the counter, and that later edges cannot advance a stopped counter. Some edges are sent on the unselected source and some while the counter is stopped, to separate counting from ignoring. Other tests acknowledge with each selector in turn, to separate "clear only" from "clear and stop" and from "clear and start". The random phase mixes byte loads biased toward the top of the range with edges on both lines and source switches. A bench model tracks the full count, so a wrong byte lane or a lost increment appears later as an early or missing interrupt.

// File: rtl/irq_wrap_pkg.sv
package irq_wrap_pkg;
    localparam int CNT_W  = 15;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STOP = 2'd1,
        SEL_LO   = 2'd2,
        SEL_HI   = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             irq;
    } timer_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rise_o
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = raw_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], raw_i};
        end
    endgenerate

    always_comb prev_d = sh_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_tick_select.sv
module irq_tick_select #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]         rise_i,
    input  logic [$clog2(N_SRC)-1:0] sel_i,
    output logic                     tick_o
);
    always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel_i == i[$clog2(N_SRC)-1:0]) tick_o = rise_i[i];
        end
    end
endmodule

// File: rtl/irq_wrap_timer.sv
module irq_wrap_timer
    import irq_wrap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       src_sel,
    input  logic       m2,
    input  logic       ppu_a12,
    output logic       irq
);
    localparam int N_SRC = 2;
    localparam int HI_W  = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N_SRC-1:0] raw_lines;
    logic [N_SRC-1:0] rises;
    logic             tick;
    timer_state_t     st_d, st_q;

    assign raw_lines = {ppu_a12, m2};

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_src
            irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .raw_i (raw_lines[g]),
                .rise_o(rises[g])
            );
        end
    endgenerate

    irq_tick_select #(.N_SRC(N_SRC)) u_sel (
        .rise_i(rises),
        .sel_i (src_sel),
        .tick_o(tick)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel_e'(wr_sel))
                SEL_STOP: begin
                    st_d.irq = 1'b0;
                    st_d.run = 1'b0;
                end
                SEL_LO: begin
                    st_d.count[BYTE_W-1:0] = wr_data;
                    st_d.irq               = 1'b0;
                end
                SEL_HI: begin
                    st_d.count[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
                    st_d.irq                   = 1'b0;
                    st_d.run                   = 1'b1;
                end
                default: ;
            endcase
        end else if (tick && st_q.run) begin
            if (st_q.count == CNT_MAX) begin
                st_d.count = '0;
                st_d.irq   = 1'b1;
                st_d.run   = 1'b0;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/irq_wrap_chk.sv
module irq_wrap_chk
    import irq_wrap_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic             run,
    input logic             irq
);
    // R5
    irq_only_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count) == '1 && $past(tick) && !$past(wr_en)));
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd0) |=> !irq);
    // R6
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> run);
    // R3
    idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(tick && run)) |=> $stable(count));
    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && tick && run) |=> count == CNT_W'($past(count) + 1'b1));
    // R7
    stop_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!run && count == '0));
endmodule

bind irq_wrap_timer irq_wrap_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_sel(wr_sel),
    .tick  (tick),
    .count (st_q.count),
    .run   (st_q.run),
    .irq   (irq)
);

// File: tb/irq_wrap_timer_test.sv
module irq_wrap_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       src_sel = 1'b0;
    logic       m2 = 1'b0;
    logic       ppu_a12 = 1'b0;
    logic       irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [14:0] m_cnt;
    logic        m_run;
    logic        m_irq;

    always #10 clk = ~clk;

    irq_wrap_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .src_sel(src_sel), .m2(m2), .ppu_a12(ppu_a12),
        .irq(irq)
    );

    function automatic void model_write(input logic [1:0] s, input logic [7:0] d);
        case (s)
            2'd1: begin m_irq = 1'b0; m_run = 1'b0; end
            2'd2: begin m_cnt[7:0] = d; m_irq = 1'b0; end
            2'd3: begin m_cnt[14:8] = d[6:0]; m_irq = 1'b0; m_run = 1'b1; end
            default: ;
        endcase
    endfunction

    function automatic void model_edge(input logic which);
        if (which == src_sel && m_run) begin
            if (m_cnt == 15'h7FFF) begin
                m_cnt = '0; m_irq = 1'b1; m_run = 1'b0;
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
        end
    endfunction

    task automatic check(input string tag, input logic exp);
        vectors++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] s, input logic [7:0] d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(s, d);
        check(tag, m_irq);
    endtask

    // R9: edge counted on third clock after sampling; check after it
    task automatic do_edge(input logic which, input string tag);
        @(negedge clk);
        if (which) ppu_a12 = 1'b1; else m2 = 1'b1;
        repeat (3) @(negedge clk);
        model_edge(which);
        check(tag, m_irq);
        if (which) ppu_a12 = 1'b0; else m2 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load(input logic [14:0] v, input string tag);
        do_write(2'd2, v[7:0], tag);
        do_write(2'd3, {1'b0, v[14:8]}, tag);
    endtask

    initial begin
        m_cnt = '0; m_run = 1'b0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset irq low", 1'b0);
        // R1: reset leaves counter stopped: edges do nothing
        do_edge(1'b0, "R1 stopped after reset");

        // R5 wrap from 7FFE needs two edges
        load(15'h7FFE, "R2 load");
        do_edge(1'b0, "R3 step no irq");
        do_edge(1'b0, "R5 wrap raises irq");
        // R7 stopped after wrap: count stays 0, irq held
        do_edge(1'b0, "R7 held after wrap");
        do_write(2'd0, 8'hFF, "R8 sel0 no effect");
        do_write(2'd2, 8'hFF, "R6 low write acks");
        // R7 restart: count now 0x00FF, enable with high 7F -> 7FFF
        do_write(2'd3, 8'hFF, "R2 high ignores bit7");
        do_edge(1'b0, "R2 R7 restart wraps");

        // R6 stop
        load(15'h7FFF, "R6 load");
        do_write(2'd1, 8'h00, "R6 stop acks");
        do_edge(1'b0, "R6 stopped ignores edge");
        do_write(2'd3, 8'h7F, "R6 restart");
        do_edge(1'b0, "R6 counts after restart");

        // R4 source select
        src_sel = 1'b1;
        load(15'h7FFF, "R4 load");
        do_edge(1'b0, "R4 m2 ignored on a12 src");
        do_edge(1'b1, "R4 a12 wraps");
        load(15'h7FFD, "R4 load2");
        do_edge(1'b1, "R4 a12 unfiltered 1");
        do_edge(1'b1, "R4 a12 unfiltered 2");
        do_edge(1'b1, "R4 a12 unfiltered 3");
        src_sel = 1'b0;

        // R8 write vs edge in same cycle: write wins
        load(15'h7FFF, "R8 load");
        @(negedge clk); m2 = 1'b1;
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        model_write(2'd2, 8'hFF);
        check("R8 write beats edge", 1'b0);
        m2 = 1'b0; repeat (3) @(negedge clk);
        do_edge(1'b0, "R8 edge after collision wraps");

        // random phase
        void'($urandom(32'd20240917));
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 2) begin
                logic [7:0] d;
                d = ($urandom_range(0, 1) == 0) ? 8'hFF - 8'($urandom_range(0, 3)) : 8'($urandom);
                do_write(2'd2, d, "R2 rand low");
            end else if (op < 4) begin
                logic [7:0] d;
                d = ($urandom_range(0, 2) != 0) ? {1'($urandom), 7'h7F} : 8'($urandom);
                do_write(2'd3, d, "R6 rand high");
            end else if (op == 4) begin
                do_write(2'($urandom_range(0, 1)), 8'($urandom), "R6 R8 rand stop/none");
            end else if (op == 5) begin
                @(negedge clk);
                src_sel = 1'($urandom);
            end else begin
                do_edge(1'($urandom), "R3 R4 R5 rand edge");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule